// File: doc/BRIEF.md
# Polynomial Audio Tone Generator

This block is a single voice of a retro-style sound source. A 4-bit waveform selector picks one of sixteen ways in which two tiny shift registers, a 4-bit waveform shaper and a 5-bit noise stage, move forward. Each time the channel's pitch divider fires, the registers take one step. Depending on the selector, a step can be a linear feedback shift, a toggle that halves the rate, a three-low/three-high pattern, or one long 9-bit noise sequence across both registers. Some selectors let the 5-bit stage gate the shaper. The gate is either a divide-by-31 condition that splits its period 13:18, or the stage's top bit.

The pitch divider counts enable ticks and fires on every (pitch code + 1)-th tick. The audible bit is the top bit of the shaper. The amplitude output carries the volume code while that bit is high and zero while it is low. Resampling and mixing several voices happen outside this block.

Top module: `poly_tone_channel`

## Requirements
- R1: While reset is asserted, and until the first pitch pulse after it, the shaper holds 4'b1111, the noise stage holds 5'b11111 and the divider count is 0. So `wave_bit` is 1 and `level` equals `vol_code`.
- R2: A pitch pulse happens on an enabled tick when the divider count has reached `freq_code`. The count then returns to 0; on other enabled ticks it increments. With `freq_code` = N, pulses come every N+1 enabled ticks. Neither register changes on a cycle without a pulse, and a cycle with `tick_en` low never pulses.
- R3: `wave_bit` is bit 3 of the shaper. `level` is `vol_code` when `wave_bit` is 1 and 0 otherwise.
- R4: A 4-bit polynomial step maps s to {s[2:0], s[3]^s[2]}, and maps 0 to 4'b0001. Selector 1 applies it to the shaper on every pulse.
- R5: A 5-bit polynomial step maps n to {n[3:0], n[4]^n[2]}, and maps 0 to 5'b00001. Selectors 2, 3, 6, 7, 9, 10, 14 and 15 apply it to the noise stage on every pulse.
- R6: Selectors 0 and 11 shift a 1 into shaper bit 0 on each pulse. Selectors 4 and 5 shift in the inverse of shaper bit 0, which halves the rate.
- R7: Selectors 2, 6 and 14 move the shaper only on a pulse where the stepped noise value has bits [3:0] equal to 4'b1000. The shaper action is the 4-bit polynomial for 2, the halving toggle for 6 and the divide-by-6 step for 14.
- R8: Selectors 3, 7 and 15 move the shaper only on a pulse where bit 4 of the stepped noise value is 1. The shaper actions are the same as in R7: polynomial, toggle and divide-by-6 respectively.
- R9: Selector 8 chains both registers. The noise stage becomes {n[3:0], s[3]^n[4]}, or 5'b00001 when both registers are zero. The shaper shifts in the old n[4].
- R10: Selector 9 shifts the old noise bit 4 into the shaper on every pulse. Selector 10 shifts the stepped noise bit 4 into the shaper, but only under the R7 condition.
- R11: Selectors 12 and 13 apply the divide-by-6 step s to {~s[2:0], ~s[2] & (s[1]|s[0])}. On steady pulses `wave_bit` then repeats three zeros and three ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_en | input | 1 | Enable tick that advances the pitch divider |
| ctrl_code | input | 4 | Waveform selector |
| freq_code | input | 5 | Pitch code; the pulse period is freq_code+1 ticks |
| vol_code | input | 4 | Amplitude applied while the wave bit is high |
| wave_bit | output | 1 | Waveform bit, shaper bit 3 |
| level | output | 4 | Amplitude output, vol_code or 0 |

## Verification
The pulse is combinational from the enabled tick and the divider count, and both registers load on that same clock edge. So `wave_bit` and `level` show the new state one edge after the tick that fires it, with no further pipeline stage. The bench drives every input at the falling edge and compares against its own reference model one nanosecond after the next rising edge. The model steps on exactly the ticks where its own counter reaches the pitch code. Idle cycles with the enable low are compared in the same slot, which shows that nothing moves without a pulse.

// File: rtl/ptone_pkg.sv
package ptone_pkg;

  localparam int SHAPER_W = 4;
  localparam int NOISE_W  = 5;
  localparam int SEL_W    = 4;

  typedef enum logic [1:0] {
    NZ_HOLD,
    NZ_POLY,
    NZ_CHAIN
  } noise_mode_e;

  typedef enum logic [1:0] {
    GT_ALWAYS,
    GT_DIV31,
    GT_NZ_TOP
  } gate_mode_e;

  typedef enum logic [2:0] {
    SH_ONE,
    SH_POLY,
    SH_TOGGLE,
    SH_DIV6,
    SH_NZ_OUT,
    SH_NZ_TOP
  } shaper_mode_e;

  typedef struct packed {
    noise_mode_e  nz;
    gate_mode_e   gate;
    shaper_mode_e sh;
  } voice_mode_t;

  // 4-bit polynomial step, taps 3 and 2, zero escapes to 1
  function automatic logic [SHAPER_W-1:0] shaper_poly(input logic [SHAPER_W-1:0] s);
    if (s == '0) return SHAPER_W'(1);
    return {s[2:0], s[3] ^ s[2]};
  endfunction

  // 5-bit polynomial step, taps 4 and 2, zero escapes to 1
  function automatic logic [NOISE_W-1:0] noise_poly(input logic [NOISE_W-1:0] n);
    if (n == '0) return NOISE_W'(1);
    return {n[3:0], n[4] ^ n[2]};
  endfunction

  // rate halving: insert complement of bit 0
  function automatic logic [SHAPER_W-1:0] shaper_toggle(input logic [SHAPER_W-1:0] s);
    return {s[2:0], ~s[0]};
  endfunction

  // three-low / three-high pattern generator
  function automatic logic [SHAPER_W-1:0] shaper_div6(input logic [SHAPER_W-1:0] s);
    return {~s[2:0], ~s[2] & (s[1] | s[0])};
  endfunction

  // 9-bit chained step for the noise half
  function automatic logic [NOISE_W-1:0] noise_chain(input logic [NOISE_W-1:0] n,
                                                    input logic [SHAPER_W-1:0] s);
    if (n == '0 && s == '0) return NOISE_W'(1);
    return {n[3:0], s[3] ^ n[4]};
  endfunction

  // divide-by-31 gate, evaluated on the stepped noise value
  function automatic logic div31_hit(input logic [NOISE_W-1:0] n);
    return n[3:0] == 4'b1000;
  endfunction

  function automatic voice_mode_t decode_sel(input logic [SEL_W-1:0] sel);
    voice_mode_t m;
    m = '{nz: NZ_HOLD, gate: GT_ALWAYS, sh: SH_ONE};
    case (sel)
      4'h0, 4'hB: m = '{nz: NZ_HOLD,  gate: GT_ALWAYS, sh: SH_ONE};
      4'h1:       m = '{nz: NZ_HOLD,  gate: GT_ALWAYS, sh: SH_POLY};
      4'h2:       m = '{nz: NZ_POLY,  gate: GT_DIV31,  sh: SH_POLY};
      4'h3:       m = '{nz: NZ_POLY,  gate: GT_NZ_TOP, sh: SH_POLY};
      4'h4, 4'h5: m = '{nz: NZ_HOLD,  gate: GT_ALWAYS, sh: SH_TOGGLE};
      4'h6:       m = '{nz: NZ_POLY,  gate: GT_DIV31,  sh: SH_TOGGLE};
      4'h7:       m = '{nz: NZ_POLY,  gate: GT_NZ_TOP, sh: SH_TOGGLE};
      4'h8:       m = '{nz: NZ_CHAIN, gate: GT_ALWAYS, sh: SH_NZ_OUT};
      4'h9:       m = '{nz: NZ_POLY,  gate: GT_ALWAYS, sh: SH_NZ_OUT};
      4'hA:       m = '{nz: NZ_POLY,  gate: GT_DIV31,  sh: SH_NZ_TOP};
      4'hC, 4'hD: m = '{nz: NZ_HOLD,  gate: GT_ALWAYS, sh: SH_DIV6};
      4'hE:       m = '{nz: NZ_POLY,  gate: GT_DIV31,  sh: SH_DIV6};
      default:    m = '{nz: NZ_POLY,  gate: GT_NZ_TOP, sh: SH_DIV6};
    endcase
    return m;
  endfunction

endpackage

// File: rtl/ptone_divider.sv
module ptone_divider #(
  parameter int FREQ_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic [FREQ_W-1:0] freq_code,
  output logic              pulse
);

  logic [FREQ_W-1:0] count_q;
  logic              at_limit;

  assign at_limit = (count_q >= freq_code);
  assign pulse    = tick_en & at_limit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
    end else if (tick_en) begin
      if (at_limit) count_q <= '0;
      else          count_q <= count_q + FREQ_W'(1);
    end
  end

endmodule

// File: rtl/ptone_mode_decode.sv
module ptone_mode_decode
  import ptone_pkg::*;
(
  input  logic [SEL_W-1:0] sel,
  output voice_mode_t      mode
);

  always_comb begin
    mode = decode_sel(sel);
  end

endmodule

// File: rtl/ptone_shaper.sv
module ptone_shaper
  import ptone_pkg::*;
#(
  parameter logic [SHAPER_W-1:0] SHAPER_SEED = '1,
  parameter logic [NOISE_W-1:0]  NOISE_SEED  = '1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                step,
  input  voice_mode_t         mode,
  output logic [SHAPER_W-1:0] shaper_q,
  output logic [NOISE_W-1:0]  noise_q,
  output logic                shaper_adv
);

  logic [NOISE_W-1:0]  noise_next;
  logic [SHAPER_W-1:0] shaper_next;
  logic                gate_open;
  logic                nz_leaving;

  assign nz_leaving = noise_q[NOISE_W-1];

  always_comb begin
    case (mode.nz)
      NZ_POLY:  noise_next = noise_poly(noise_q);
      NZ_CHAIN: noise_next = noise_chain(noise_q, shaper_q);
      default:  noise_next = noise_q;
    endcase
  end

  always_comb begin
    case (mode.gate)
      GT_DIV31:  gate_open = div31_hit(noise_next);
      GT_NZ_TOP: gate_open = noise_next[NOISE_W-1];
      default:   gate_open = 1'b1;
    endcase
  end

  always_comb begin
    case (mode.sh)
      SH_POLY:   shaper_next = shaper_poly(shaper_q);
      SH_TOGGLE: shaper_next = shaper_toggle(shaper_q);
      SH_DIV6:   shaper_next = shaper_div6(shaper_q);
      SH_NZ_OUT: shaper_next = {shaper_q[SHAPER_W-2:0], nz_leaving};
      SH_NZ_TOP: shaper_next = {shaper_q[SHAPER_W-2:0], noise_next[NOISE_W-1]};
      default:   shaper_next = {shaper_q[SHAPER_W-2:0], 1'b1};
    endcase
  end

  assign shaper_adv = step & gate_open;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      noise_q  <= NOISE_SEED;
      shaper_q <= SHAPER_SEED;
    end else begin
      if (step)       noise_q  <= noise_next;
      if (shaper_adv) shaper_q <= shaper_next;
    end
  end

endmodule

// File: rtl/poly_tone_channel.sv
module poly_tone_channel
  import ptone_pkg::*;
#(
  parameter int FREQ_W = 5,
  parameter int VOL_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic [3:0]        ctrl_code,
  input  logic [FREQ_W-1:0] freq_code,
  input  logic [VOL_W-1:0]  vol_code,
  output logic              wave_bit,
  output logic [VOL_W-1:0]  level
);

  localparam int WAVE_IDX = SHAPER_W - 1;

  voice_mode_t         mode;
  logic                step_pulse;
  logic                shaper_adv;
  logic [SHAPER_W-1:0] p4_q;
  logic [NOISE_W-1:0]  p5_q;

  ptone_mode_decode u_decode (
    .sel  (ctrl_code),
    .mode (mode)
  );

  ptone_divider #(.FREQ_W(FREQ_W)) u_div (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_en   (tick_en),
    .freq_code (freq_code),
    .pulse     (step_pulse)
  );

  ptone_shaper u_shaper (
    .clk        (clk),
    .rst_n      (rst_n),
    .step       (step_pulse),
    .mode       (mode),
    .shaper_q   (p4_q),
    .noise_q    (p5_q),
    .shaper_adv (shaper_adv)
  );

  assign wave_bit = p4_q[WAVE_IDX];

  always_comb begin
    level = wave_bit ? vol_code : '0;
  end

endmodule

// File: rtl/ptone_checker.sv
module ptone_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       tick_en,
  input logic [3:0] ctrl_code,
  input logic       step_pulse,
  input logic [3:0] p4_q,
  input logic [4:0] p5_q
);

  logic grp_div31;
  logic grp_top;
  logic grp_one;

  assign grp_div31 = (ctrl_code == 4'h2) || (ctrl_code == 4'h6) || (ctrl_code == 4'hE);
  assign grp_top   = (ctrl_code == 4'h3) || (ctrl_code == 4'h7) || (ctrl_code == 4'hF);
  assign grp_one   = (ctrl_code == 4'h0) || (ctrl_code == 4'hB);

  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !step_pulse |=> ($stable(p4_q) && $stable(p5_q)));

  assert_pulse_needs_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
    step_pulse |-> tick_en);

  assert_const_one_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (step_pulse && grp_one) |=> p4_q[0]);

  assert_div31_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (step_pulse && grp_div31) |=> ((p4_q != $past(p4_q)) == (p5_q[3:0] == 4'b1000)));

  assert_top_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (step_pulse && grp_top) |=> ((p4_q != $past(p4_q)) == p5_q[4]));

  assert_noise_alive_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (step_pulse && (grp_div31 || grp_top || ctrl_code == 4'h9 || ctrl_code == 4'hA))
      |=> (p5_q != 5'd0));

  assert_chain_feed_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (step_pulse && ctrl_code == 4'h8) |=> (p4_q[0] == $past(p5_q[4])));

endmodule

bind poly_tone_channel ptone_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .tick_en    (tick_en),
  .ctrl_code  (ctrl_code),
  .step_pulse (step_pulse),
  .p4_q       (p4_q),
  .p5_q       (p5_q)
);

// File: tb/poly_tone_channel_tb.sv
`timescale 1ns/1ps
module poly_tone_channel_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_en = 1'b0;
  logic [3:0] ctrl_code = 4'h0;
  logic [4:0] freq_code = 5'd0;
  logic [3:0] vol_code = 4'h0;
  logic       wave_bit;
  logic [3:0] level;

  always #2.5 clk = ~clk;

  poly_tone_channel dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_en   (tick_en),
    .ctrl_code (ctrl_code),
    .freq_code (freq_code),
    .vol_code  (vol_code),
    .wave_bit  (wave_bit),
    .level     (level)
  );

  int n_checks = 0;
  int n_fails  = 0;
  int m4, m5, mcnt;
  bit finished = 1'b0;

  typedef struct packed {
    logic [3:0] sel;
    logic [4:0] freq;
    logic [3:0] vol;
    logic [7:0] ticks;
    logic       idle;
  } vec_t;

  localparam int NVEC = 20;
  localparam vec_t VECS [NVEC] = '{
    '{4'h0, 5'd0, 4'd9,  8'd12, 1'b0},
    '{4'h1, 5'd0, 4'd15, 8'd40, 1'b0},
    '{4'h2, 5'd0, 4'd7,  8'd90, 1'b0},
    '{4'h3, 5'd1, 4'd5,  8'd90, 1'b0},
    '{4'h4, 5'd2, 4'd3,  8'd30, 1'b1},
    '{4'h5, 5'd0, 4'd12, 8'd20, 1'b0},
    '{4'h6, 5'd0, 4'd6,  8'd90, 1'b0},
    '{4'h7, 5'd0, 4'd11, 8'd80, 1'b1},
    '{4'h8, 5'd0, 4'd13, 8'd120, 1'b0},
    '{4'h9, 5'd0, 4'd2,  8'd70, 1'b0},
    '{4'hA, 5'd0, 4'd8,  8'd100, 1'b0},
    '{4'hB, 5'd3, 4'd1,  8'd20, 1'b0},
    '{4'hC, 5'd0, 4'd10, 8'd30, 1'b0},
    '{4'hD, 5'd1, 4'd14, 8'd30, 1'b1},
    '{4'hE, 5'd0, 4'd4,  8'd100, 1'b0},
    '{4'hF, 5'd0, 4'd15, 8'd90, 1'b0},
    '{4'h4, 5'd31, 4'd7, 8'd100, 1'b0},
    '{4'h1, 5'd5,  4'd9, 8'd60, 1'b1},
    '{4'hC, 5'd31, 4'd3, 8'd80, 1'b0},
    '{4'h8, 5'd2,  4'd6, 8'd60, 1'b0}
  };

  function automatic string tag_of(input logic [3:0] sel);
    case (sel)
      4'h0, 4'hB, 4'h4, 4'h5: return "R6";
      4'h1:                   return "R4";
      4'h2, 4'h6, 4'hE:       return "R7";
      4'h3, 4'h7, 4'hF:       return "R8";
      4'h8:                   return "R9";
      4'h9:                   return "R5,R10";
      4'hA:                   return "R10";
      default:                return "R11";
    endcase
  endfunction

  // independent reference arithmetic on plain integers
  function automatic int ref_p4poly(input int v);
    if ((v & 15) == 0) return 1;
    return ((v * 2) & 15) + (((v >> 3) + (v >> 2)) % 2);
  endfunction

  function automatic int ref_p5poly(input int v);
    if ((v & 31) == 0) return 1;
    return ((v * 2) & 31) + (((v >> 4) + (v >> 2)) % 2);
  endfunction

  function automatic int ref_div6(input int v);
    int low;
    low = v % 8;
    return ((7 - low) * 2) + ((low == 1 || low == 2 || low == 3) ? 1 : 0);
  endfunction

  function automatic int ref_shift(input int v, input int b);
    return ((v * 2) & 15) + (b & 1);
  endfunction

  task automatic model_step(input int sel);
    int old5;
    int n5;
    bit gate;
    old5 = m5;
    case (sel)
      0, 11:  m4 = ref_shift(m4, 1);
      1:      m4 = ref_p4poly(m4);
      4, 5:   m4 = ref_shift(m4, 1 - (m4 % 2));
      12, 13: m4 = ref_div6(m4);
      8: begin
        if (m5 == 0 && m4 == 0) n5 = 1;
        else n5 = ((m5 * 2) & 31) + (((m4 >> 3) + (m5 >> 4)) % 2);
        m4 = ref_shift(m4, old5 >> 4);
        m5 = n5;
      end
      9: begin
        m5 = ref_p5poly(m5);
        m4 = ref_shift(m4, old5 >> 4);
      end
      default: begin
        m5 = ref_p5poly(m5);
        if (sel == 2 || sel == 6 || sel == 10 || sel == 14) gate = ((m5 % 16) == 8);
        else gate = ((m5 >> 4) == 1);
        if (gate) begin
          case (sel)
            2, 3:   m4 = ref_p4poly(m4);
            6, 7:   m4 = ref_shift(m4, 1 - (m4 % 2));
            10:     m4 = ref_shift(m4, m5 >> 4);
            default: m4 = ref_div6(m4);
          endcase
        end
      end
    endcase
  endtask

  task automatic check(input string req, input logic [4:0] act, input logic [4:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: {wave,level} actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [4:0] expect_out();
    logic w;
    w = ((m4 >> 3) % 2) == 1;
    return {w, w ? vol_code : 4'h0};
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    tick_en = 1'b0;
    repeat (2) @(negedge clk);
    m4 = 15; m5 = 31; mcnt = 0;
    #1;
    check("R1", {wave_bit, level}, expect_out());
    rst_n = 1'b1;
  endtask

  // one cycle: drive at falling edge, compare 1 ns after rising edge
  task automatic cycle(input bit en, input string req);
    @(negedge clk);
    tick_en = en;
    @(posedge clk);
    if (en) begin
      if (mcnt >= int'(freq_code)) begin
        mcnt = 0;
        model_step(int'(ctrl_code));
      end else begin
        mcnt++;
      end
    end
    #1;
    check(req, {wave_bit, level}, expect_out());
  endtask

  initial begin : watchdog
    #500000;
    if (!finished) begin
      n_fails++;
      n_checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  end

  initial begin : main
    // R1: reset state and outputs before any pulse
    vol_code = 4'd11;
    do_reset();

    for (int v = 0; v < NVEC; v++) begin
      ctrl_code = VECS[v].sel;
      freq_code = VECS[v].freq;
      vol_code  = VECS[v].vol;
      do_reset();
      for (int t = 0; t < int'(VECS[v].ticks); t++) begin
        cycle(1'b1, tag_of(VECS[v].sel));
        // R2: a disabled cycle must change nothing
        if (VECS[v].idle) cycle(1'b0, "R2");
      end
    end

    // R2: pitch code 31 with enable low for a long stretch, then at the limit
    ctrl_code = 4'h4; freq_code = 5'd31; vol_code = 4'd5;
    do_reset();
    for (int t = 0; t < 10; t++) cycle(1'b0, "R2");
    for (int t = 0; t < 64; t++) cycle(1'b1, "R2");

    // R3: volume change while wave is high and low, no pulse
    ctrl_code = 4'h0; freq_code = 5'd0; vol_code = 4'd7;
    do_reset();
    vol_code = 4'd2;
    cycle(1'b0, "R3");
    ctrl_code = 4'hC;
    for (int t = 0; t < 8; t++) begin
      vol_code = 4'(t + 3);
      cycle(1'b1, "R3");
    end

    // R11: six-step pattern of wave bit from a clean reset, explicit values
    ctrl_code = 4'hD; freq_code = 5'd0; vol_code = 4'd1;
    do_reset();
    for (int t = 0; t < 2; t++) cycle(1'b1, "R11");
    begin
      logic [5:0] seen;
      for (int t = 0; t < 6; t++) begin
        cycle(1'b1, "R11");
        seen[t] = wave_bit;
      end
      n_checks++;
      if ($countones(seen) != 3) begin
        n_fails++;
        $display("FAIL R11: ones in six steps actual %0d expected 3", $countones(seen));
      end
    end

    // R1: reset in mid-run restores seeds
    ctrl_code = 4'h9; freq_code = 5'd0; vol_code = 4'd6;
    for (int t = 0; t < 7; t++) cycle(1'b1, "R10");
    do_reset();
    cycle(1'b0, "R1");

    // R9: mode switch into chained mode keeps state continuous
    ctrl_code = 4'h3;
    for (int t = 0; t < 20; t++) cycle(1'b1, "R8");
    ctrl_code = 4'h8;
    for (int t = 0; t < 40; t++) cycle(1'b1, "R9");

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

endmodule